// File: doc/BRIEF.md
# Per-Interrupt Core Routing Unit

This block sits between a set of interrupt sources and the interrupt inputs of several CPU cores. It decides which cores see each source. For every device number it keeps a global enable bit, a routing mask with one bit per core, and a fixed capability word. The capability word states which cores the source can reach, whether it may target more than one core at once, and whether it is private to one core.

The first `NUM_CORES` device numbers are private sources, one per core, such as a core's own timer. Device `d` in that range belongs to core `d`, its routing is fixed to that core, and only that core may change its enable bit. The other device numbers are shared peripheral sources. Any core can enable or disable them and can steer them to any core they can reach.

Software reaches the block through a single request channel. A request carries an operation code, a device number, a routing mask and the requesting core's ID. A request-handling state machine moves through the states IDLE, EXEC and RESP. In IDLE it accepts a request ("accept"). In EXEC it carries out the request and registers the result ("execute"). In RESP it presents the result for one cycle and returns to IDLE ("complete"). The per-core interrupt outputs are registered. Each output is the OR of every source that is requesting, enabled and routed to that core.

Top module: `irq_core_router`

## Requirements
- R1: After reset every device is disabled and `irq_out` is zero. Every private device is routed to its owner core. Every shared device is routed to its lowest reachable core, which is core 0 whenever core 0 is reachable.
- R2: ENABLE (op 0) and DISABLE (op 1) return 1 in bit 0 when the device was enabled before the request and 0 when it was disabled. All other result bits are zero. The new enable state takes effect for later requests.
- R3: `irq_out[c]` is 1 exactly when some device is requesting on `irq_src`, is enabled, and has bit `c` set in its routing mask. It follows its inputs with one register stage.
- R4: SET_ROUTE (op 2) on a shared device first clears the requested mask bits outside the device's reach. It writes the result, returns the applied mask, and GET_ROUTE (op 3) later returns the same mask. Bit N of a mask stands for core N.
- R5: For a shared device that may not target several cores, a SET_ROUTE whose clipped mask has more than one bit set keeps only the lowest of those bits.
- R6: PROPERTIES (op 4) returns the reachable cores in bits 15:0. Bit 31 is 1 when several cores may be targeted at once. Bit 30 is 1 when enable and disable work only from the core the device is routed to, which is the case for private devices. Bits 29:16 read as zero.
- R7: STATUS (op 5) returns the raw `irq_src` bit of the device in bit 0, whatever its enable state.
- R8: An ENABLE or DISABLE of a private device from a core other than its owner changes nothing and returns the current enable state. SET_ROUTE on a private device changes nothing and returns the owner-only mask.
- R9: A request whose device number is `NUM_DEV` or above, or whose op code is 6 or 7, changes no state and returns zero.
- R10: `req_ready` is 1 only in IDLE, and a request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `resp_valid` is 1 for exactly one cycle, two clock edges after acceptance, with the result on `resp_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_DEV | Raw request line of each device |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 3 | Operation code |
| req_dev | input | DEV_W | Device number, including out-of-range values |
| req_core | input | CORE_W | ID of the requesting core |
| req_data | input | NUM_CORES | Requested routing mask |
| resp_valid | output | 1 | Result valid for one cycle |
| resp_data | output | 32 | Result word |
| irq_out | output | NUM_CORES | Registered interrupt request to each core |

## Verification
The hardest cases to reach are two kinds of request that look valid but must leave state untouched. The first is a private-device enable sent from a non-owner core. The second is a routing write whose requested bits all fall outside a device's reach, which must leave the device routed nowhere. Uniform random stimulus rarely lines either of these up with a source that is already requesting.

Directed steps set these cases up explicitly, and each one is followed by an output check with every source held high. After that, random operations are biased toward a small range of device numbers that includes out-of-range ones. The bench compares every result and every `irq_out` value against a reference state kept in the bench.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    typedef enum logic [2:0] {
        OP_ENABLE    = 3'd0,
        OP_DISABLE   = 3'd1,
        OP_SET_ROUTE = 3'd2,
        OP_GET_ROUTE = 3'd3,
        OP_PROPS     = 3'd4,
        OP_STATUS    = 3'd5,
        OP_RSVD6     = 3'd6,
        OP_RSVD7     = 3'd7
    } route_op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EXEC = 2'd1,
        S_RESP = 2'd2
    } req_state_e;

    localparam int PROP_MULTI_BIT = 31;
    localparam int PROP_LOCAL_BIT = 30;
    localparam int REACH_FIELD_W  = 16;

endpackage

// File: rtl/route_clip.sv
module route_clip #(
    parameter int NUM_CORES = 4
) (
    input  logic [NUM_CORES-1:0] want,
    input  logic [NUM_CORES-1:0] reach,
    input  logic                 multi_ok,
    output logic [NUM_CORES-1:0] applied
);
    logic [NUM_CORES-1:0] masked;

    always_comb begin
        masked = want & reach;
        if (multi_ok)
            applied = masked;
        else
            applied = masked & (~masked + NUM_CORES'(1));
    end

    always_comb begin
        assert ((applied & ~reach) == '0);
    end

endmodule

// File: rtl/dev_state.sv
module dev_state #(
    parameter int NUM_DEV   = 8,
    parameter int NUM_CORES = 4,
    parameter int DEV_W     = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           en_we,
    input  logic                           en_val,
    input  logic                           rt_we,
    input  logic [DEV_W-1:0]               wr_dev,
    input  logic [NUM_CORES-1:0]           rt_val,
    input  logic [NUM_DEV*NUM_CORES-1:0]   rst_route,
    input  logic [NUM_DEV*NUM_CORES-1:0]   reach_flat,
    input  logic [NUM_DEV-1:0]             multi_vec,
    output logic [NUM_DEV-1:0]             en_vec,
    output logic [NUM_DEV*NUM_CORES-1:0]   rt_flat
);
    import irq_route_pkg::*;

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        logic [NUM_CORES-1:0] rt_r;
        logic                 en_r;
        logic                 hit;

        assign hit = (wr_dev == DEV_W'(d));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_r <= 1'b0;
                rt_r <= rst_route[d*NUM_CORES +: NUM_CORES];
            end else begin
                if (en_we && hit)
                    en_r <= en_val;
                if (rt_we && hit)
                    rt_r <= rt_val;
            end
        end

        assign en_vec[d] = en_r;
        assign rt_flat[d*NUM_CORES +: NUM_CORES] = rt_r;

        p_route_in_reach_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (rt_r & ~reach_flat[d*NUM_CORES +: NUM_CORES]) == '0);

        p_single_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !multi_vec[d] |-> $onehot0(rt_r));

        if (d < NUM_CORES) begin : g_priv
            p_private_route_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
                rt_r == NUM_CORES'(1) << d);
        end
    end

endmodule

// File: rtl/irq_fanout.sv
module irq_fanout #(
    parameter int NUM_DEV   = 8,
    parameter int NUM_CORES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_DEV-1:0]            src,
    input  logic [NUM_DEV-1:0]            en_vec,
    input  logic [NUM_DEV*NUM_CORES-1:0]  rt_flat,
    output logic [NUM_CORES-1:0]          irq_out
);
    logic [NUM_CORES-1:0] hit_c;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic [NUM_DEV-1:0] col;
        for (genvar d = 0; d < NUM_DEV; d++) begin : g_col
            assign col[d] = rt_flat[d*NUM_CORES + c];
        end
        assign hit_c[c] = |(src & en_vec & col);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_out <= '0;
        else
            irq_out <= hit_c;
    end

    p_out_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_out) |-> $past(|(src & en_vec)));

endmodule

// File: rtl/req_fsm.sv
module req_fsm #(
    parameter int NUM_DEV   = 8,
    parameter int NUM_CORES = 4,
    parameter int DEV_W     = 4,
    parameter int CORE_W    = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [2:0]                    req_op,
    input  logic [DEV_W-1:0]              req_dev,
    input  logic [CORE_W-1:0]             req_core,
    input  logic [NUM_CORES-1:0]          req_data,
    input  logic [NUM_DEV-1:0]            src,
    input  logic [NUM_DEV-1:0]            en_vec,
    input  logic [NUM_DEV*NUM_CORES-1:0]  rt_flat,
    input  logic [NUM_DEV*NUM_CORES-1:0]  reach_flat,
    input  logic [NUM_DEV-1:0]            multi_vec,
    input  logic [NUM_DEV-1:0]            local_vec,
    output logic                          req_ready,
    output logic                          resp_valid,
    output logic [31:0]                   resp_data,
    output logic                          en_we,
    output logic                          en_val,
    output logic                          rt_we,
    output logic [NUM_CORES-1:0]          rt_val,
    output logic [DEV_W-1:0]              wr_dev
);
    import irq_route_pkg::*;

    localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    req_state_e           state, state_nx;
    route_op_e            op_q;
    logic [DEV_W-1:0]     dev_q;
    logic [CORE_W-1:0]    core_q;
    logic [NUM_CORES-1:0] data_q;
    logic [31:0]          resp_q;
    logic [31:0]          result_c;

    logic [NUM_CORES-1:0] rt_arr    [NUM_DEV];
    logic [NUM_CORES-1:0] reach_arr [NUM_DEV];

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_unpack
        assign rt_arr[d]    = rt_flat[d*NUM_CORES +: NUM_CORES];
        assign reach_arr[d] = reach_flat[d*NUM_CORES +: NUM_CORES];
    end

    logic                 in_range;
    logic [IDX_W-1:0]     idx;
    logic                 cur_en, cur_src, cur_multi, cur_local, owner_ok;
    logic [NUM_CORES-1:0] cur_rt, cur_reach, clip_mask;
    logic [31:0]          prop_word;

    assign in_range = (dev_q < DEV_W'(NUM_DEV));
    assign idx      = dev_q[IDX_W-1:0];

    always_comb begin
        cur_en    = 1'b0;
        cur_src   = 1'b0;
        cur_multi = 1'b0;
        cur_local = 1'b0;
        cur_rt    = '0;
        cur_reach = '0;
        if (in_range) begin
            cur_en    = en_vec[idx];
            cur_src   = src[idx];
            cur_multi = multi_vec[idx];
            cur_local = local_vec[idx];
            cur_rt    = rt_arr[idx];
            cur_reach = reach_arr[idx];
        end
        owner_ok = !cur_local || (int'(core_q) == int'(idx));
        prop_word = '0;
        prop_word[NUM_CORES-1:0] = cur_reach;
        prop_word[PROP_MULTI_BIT] = cur_multi;
        prop_word[PROP_LOCAL_BIT] = cur_local;
    end

    route_clip #(.NUM_CORES(NUM_CORES)) i_clip (
        .want     (data_q),
        .reach    (cur_reach),
        .multi_ok (cur_multi),
        .applied  (clip_mask)
    );

    // state register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op_q   <= OP_RSVD7;
            dev_q  <= '0;
            core_q <= '0;
            data_q <= '0;
            resp_q <= '0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && req_valid) begin
                op_q   <= route_op_e'(req_op);
                dev_q  <= req_dev;
                core_q <= req_core;
                data_q <= req_data;
            end
            if (state == S_EXEC)
                resp_q <= result_c;
        end
    end

    // transitions: accept, execute, complete
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_valid) state_nx = S_EXEC;
            S_EXEC:  state_nx = S_RESP;
            S_RESP:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        en_we      = 1'b0;
        en_val     = 1'b0;
        rt_we      = 1'b0;
        rt_val     = clip_mask;
        result_c   = '0;
        unique case (state)
            S_IDLE: req_ready = 1'b1;
            S_EXEC: begin
                if (in_range) begin
                    unique case (op_q)
                        OP_ENABLE, OP_DISABLE: begin
                            result_c = {31'b0, cur_en};
                            en_we    = owner_ok;
                            en_val   = (op_q == OP_ENABLE);
                        end
                        OP_SET_ROUTE: begin
                            if (cur_local) begin
                                result_c = 32'(cur_rt);
                            end else begin
                                rt_we    = 1'b1;
                                result_c = 32'(clip_mask);
                            end
                        end
                        OP_GET_ROUTE: result_c = 32'(cur_rt);
                        OP_PROPS:     result_c = prop_word;
                        OP_STATUS:    result_c = {31'b0, cur_src};
                        default:      result_c = '0;
                    endcase
                end
            end
            S_RESP: resp_valid = 1'b1;
            default: ;
        endcase
    end

    assign resp_data = resp_q;
    assign wr_dev    = dev_q;

    p_resp_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_ready_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready ##1 resp_valid);

    p_out_of_range_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !in_range) |-> resp_data == '0);

    p_enable_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (op_q == OP_ENABLE || op_q == OP_DISABLE)) |-> resp_data[31:1] == '0);

endmodule

// File: rtl/irq_core_router.sv
module irq_core_router #(
    parameter int                          NUM_CORES    = 4,
    parameter int                          NUM_DEV      = 8,
    parameter int                          DEV_W        = $clog2(NUM_DEV) + 1,
    parameter int                          CORE_W       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    parameter logic [NUM_DEV*NUM_CORES-1:0] SHARED_REACH = 32'h6EFF_0000,
    parameter logic [NUM_DEV-1:0]           MULTI_DEV    = 8'b1010_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_DEV-1:0]   irq_src,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [2:0]           req_op,
    input  logic [DEV_W-1:0]     req_dev,
    input  logic [CORE_W-1:0]    req_core,
    input  logic [NUM_CORES-1:0] req_data,
    output logic                 resp_valid,
    output logic [31:0]          resp_data,
    output logic [NUM_CORES-1:0] irq_out
);
    logic [NUM_DEV*NUM_CORES-1:0] reach_flat, rst_route, rt_flat;
    logic [NUM_DEV-1:0]           multi_vec, local_vec, en_vec;
    logic                         en_we, en_val, rt_we;
    logic [NUM_CORES-1:0]         rt_val;
    logic [DEV_W-1:0]             wr_dev;

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_cap
        logic [NUM_CORES-1:0] r;
        if (d < NUM_CORES) begin : g_priv
            assign r            = NUM_CORES'(1) << d;
            assign multi_vec[d] = 1'b0;
            assign local_vec[d] = 1'b1;
        end else begin : g_shared
            assign r            = SHARED_REACH[d*NUM_CORES +: NUM_CORES];
            assign multi_vec[d] = MULTI_DEV[d];
            assign local_vec[d] = 1'b0;
        end
        assign reach_flat[d*NUM_CORES +: NUM_CORES] = r;
        assign rst_route[d*NUM_CORES +: NUM_CORES]  = r & (~r + NUM_CORES'(1));
    end

    req_fsm #(
        .NUM_DEV(NUM_DEV), .NUM_CORES(NUM_CORES), .DEV_W(DEV_W), .CORE_W(CORE_W)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_dev(req_dev),
        .req_core(req_core), .req_data(req_data),
        .src(irq_src), .en_vec(en_vec), .rt_flat(rt_flat),
        .reach_flat(reach_flat), .multi_vec(multi_vec), .local_vec(local_vec),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .en_we(en_we), .en_val(en_val), .rt_we(rt_we), .rt_val(rt_val),
        .wr_dev(wr_dev)
    );

    dev_state #(
        .NUM_DEV(NUM_DEV), .NUM_CORES(NUM_CORES), .DEV_W(DEV_W)
    ) i_state (
        .clk(clk), .rst_n(rst_n),
        .en_we(en_we), .en_val(en_val), .rt_we(rt_we),
        .wr_dev(wr_dev), .rt_val(rt_val),
        .rst_route(rst_route), .reach_flat(reach_flat), .multi_vec(multi_vec),
        .en_vec(en_vec), .rt_flat(rt_flat)
    );

    irq_fanout #(
        .NUM_DEV(NUM_DEV), .NUM_CORES(NUM_CORES)
    ) i_fanout (
        .clk(clk), .rst_n(rst_n),
        .src(irq_src), .en_vec(en_vec), .rt_flat(rt_flat),
        .irq_out(irq_out)
    );

endmodule

// File: tb/test_irq_core_router.sv
module test_irq_core_router;

    localparam int NC = 4;
    localparam int ND = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [ND-1:0] irq_src = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = '0;
    logic [3:0]    req_dev = '0;
    logic [1:0]    req_core = '0;
    logic [NC-1:0] req_data = '0;
    logic          resp_valid;
    logic [31:0]   resp_data;
    logic [NC-1:0] irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic          en_m [ND];
    logic [NC-1:0] rt_m [ND];

    always #5 clk = ~clk;

    irq_core_router i_irq_core_router (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_dev(req_dev), .req_core(req_core), .req_data(req_data),
        .resp_valid(resp_valid), .resp_data(resp_data), .irq_out(irq_out)
    );

    function automatic logic [NC-1:0] reach_of(int d);
        case (d)
            0: return 4'b0001;
            1: return 4'b0010;
            2: return 4'b0100;
            3: return 4'b1000;
            4: return 4'b1111;
            5: return 4'b1111;
            6: return 4'b1110;
            default: return 4'b0110;
        endcase
    endfunction

    function automatic bit multi_of(int d);
        return (d == 5) || (d == 7);
    endfunction

    function automatic logic [NC-1:0] lowest(logic [NC-1:0] m);
        for (int i = 0; i < NC; i++)
            if (m[i]) return NC'(1) << i;
        return '0;
    endfunction

    function automatic logic [NC-1:0] exp_irq();
        logic [NC-1:0] r = '0;
        for (int d = 0; d < ND; d++)
            if (irq_src[d] && en_m[d]) r |= rt_m[d];
        return r;
    endfunction

    task automatic check(logic [31:0] act, logic [31:0] exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_req(int op, int dev, int core, logic [NC-1:0] data, string req);
        logic [31:0] exp = '0;
        bit inr = (dev < ND);
        bit priv = inr && (dev < NC);
        if (inr) begin
            case (op)
                0, 1: begin
                    exp = {31'b0, en_m[dev]};
                    if (!priv || core == dev) en_m[dev] = (op == 0);
                end
                2: begin
                    if (priv) exp = 32'(rt_m[dev]);
                    else begin
                        logic [NC-1:0] m = data & reach_of(dev);
                        if (!multi_of(dev)) m = lowest(m);
                        rt_m[dev] = m;
                        exp = 32'(m);
                    end
                end
                3: exp = 32'(rt_m[dev]);
                4: begin
                    exp = 32'(reach_of(dev));
                    exp[31] = multi_of(dev);
                    exp[30] = priv;
                end
                5: exp = {31'b0, irq_src[dev]};
                default: exp = '0;
            endcase
        end
        @(negedge clk);
        check({31'b0, req_ready}, 32'd1, "R10 ready");
        req_valid = 1'b1;
        req_op = 3'(op);
        req_dev = 4'(dev);
        req_core = 2'(core);
        req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check({31'b0, resp_valid}, 32'd1, "R10 resp_valid");
        check(resp_data, exp, req);
        @(negedge clk);
        check({31'b0, resp_valid}, 32'd0, "R10 single pulse");
        check(32'(irq_out), 32'(exp_irq()), "R3 irq_out");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int d = 0; d < ND; d++) begin
            en_m[d] = 1'b0;
            rt_m[d] = (d < NC) ? reach_of(d) : lowest(reach_of(d));
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        irq_src = '1;
        @(negedge clk);
        @(negedge clk);
        check(32'(irq_out), 32'd0, "R1 irq_out after reset");
        for (int d = 0; d < ND; d++) do_req(3, d, 0, '0, "R1 reset route");
        for (int d = 0; d < ND; d++) do_req(4, d, 0, '0, "R6 properties");

        do_req(5, 4, 0, '0, "R7 status while disabled");
        do_req(0, 4, 1, '0, "R2 enable returns 0");
        do_req(0, 4, 2, '0, "R2 enable returns 1");
        do_req(2, 4, 0, 4'b1100, "R5 single target lowest");
        do_req(3, 4, 0, '0, "R4 get after set");
        do_req(2, 5, 1, 4'b1011, "R4 multi target");
        do_req(0, 5, 3, '0, "R2 enable dev5");
        do_req(2, 6, 0, 4'b0001, "R4 outside reach clipped");
        do_req(0, 6, 0, '0, "R2 enable dev6 routed nowhere");
        do_req(2, 7, 0, 4'b1111, "R4 R5 multi partial reach");
        do_req(0, 2, 1, '0, "R8 foreign enable ignored");
        do_req(0, 2, 1, '0, "R8 still disabled");
        do_req(0, 2, 2, '0, "R8 owner enable");
        do_req(1, 2, 0, '0, "R8 foreign disable ignored");
        do_req(2, 1, 1, 4'b1111, "R8 private route fixed");
        do_req(0, 15, 0, '0, "R9 out of range");
        do_req(2, 9, 0, 4'b1111, "R9 out of range route");
        do_req(6, 4, 0, '0, "R9 reserved op");
        do_req(1, 4, 0, '0, "R2 disable returns 1");
        do_req(1, 4, 0, '0, "R2 disable returns 0");

        for (int i = 0; i < 400; i++) begin
            irq_src = ND'($urandom);
            do_req(int'($urandom_range(0, 7)), int'($urandom_range(0, 9)),
                   int'($urandom_range(0, 3)), NC'($urandom), "R2-mix random op");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule